// File: doc/BRIEF.md
# Bit-Header Command Handshake Slave

This block is the device side of a job exchange between a host and a tag access engine. The two sides talk through two shared buffers of equal, even size. The host writes the output buffer and the block reads it. The block drives the input buffer and the host reads it. Byte 0 of each buffer is a header of flag bits. When the dual-header option is on, the last byte of each buffer holds a copy of that header. The block checks this copy on the host side and produces it on the device side.

A job starts when the command-valid bit rises. The block reads the command, start address and byte count from the output buffer and then answers through level flags: started, finished and failed. Payload moves in chunks. A toggle bit on each side paces the chunks, so a host that only polls can never lose or repeat a chunk. Tag memory is reached through a simple one-byte request/acknowledge stub port.

Top module: `bithdr_slave`

## Requirements
- R1: A job starts only on a rise of the host command-valid bit (output byte 0, bit 0) while the block is idle. On a valid job the started flag (input byte 0, bit 1) is set one cycle later and the ready flag (bit 7) drops. A valid bit that stays high never starts a second job.
- R2: Output byte 1 is the command: 01h reads and 02h writes. Bytes 2 and 3 hold the start address, low byte first. Bytes 4 and 5 hold the byte count, low byte first. Any other command, or a count of zero, sets the failed flag (bit 3) with code 07h in input byte 1, and the started flag stays clear.
- R3: With the dual header on, if output byte 0 differs from the last output byte when a job starts, the job fails with code 0Fh. This check ranks above the command check.
- R4: A read delivers data in chunks of up to BUF_BYTES-1-DUAL_HDR bytes in input bytes 1 and up. The block inverts its toggle bit (bit 5) when a chunk is ready. It fetches the next chunk only after the host inverts its toggle bit (output byte 0, bit 2).
- R5: A write inverts the device toggle bit when the job is accepted and after each chunk that is not the last. On each inversion of the host toggle bit, the block writes the next chunk from output bytes 1 and up to consecutive tag addresses.
- R6: The finished flag (bit 2) is set once the last byte has moved. On a read it rises together with the final toggle inversion. The finished and failed flags are never set together.
- R7: One cycle after the host clears the command-valid bit, the started, finished and failed flags are clear and the ready flag is set.
- R8: While the ground-state bit (output byte 0, bit 1) is high, any job is abandoned: all three job flags are clear, ready is set and no tag request is made.
- R9: Input byte 0 shows head fault on bit 6, the digital input on bit 4 and tag presence on bit 0, each one cycle after the matching input pin.
- R10: With the dual header on, the last input byte equals input byte 0 in every cycle.
- R11: The block-size bit (output byte 0, bit 3) is captured when a job is accepted and held on the tag block-size output for that job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hbuf_i | input | BUF_BYTES*8 | Host output buffer, byte k at bits 8k+7:8k |
| dbuf_o | output | BUF_BYTES*8 | Device input buffer, same byte layout |
| tag_present_i | input | 1 | A tag is in the head's field |
| head_fault_i | input | 1 | Head cable broken or head missing |
| dig_in_i | input | 1 | Digital input shown in the header |
| tag_req_o | output | 1 | Tag byte access request |
| tag_we_o | output | 1 | Access is a write |
| tag_addr_o | output | 16 | Tag byte address |
| tag_wdata_o | output | 8 | Byte to write |
| tag_rdata_i | input | 8 | Byte read, valid with acknowledge |
| tag_ack_i | input | 1 | Access completes this cycle |
| tag_blk64_o | output | 1 | Block-size selection of the current job |

## Verification
The hardest case to reach is a ground-state request that lands in the middle of a multi-chunk read while the command-valid bit is still high. Afterwards, releasing the ground-state bit must not restart the job. The bench starts a 30-byte read, waits for the first chunk's toggle, raises the ground-state bit, and then drops it with the valid bit still held. It checks that no job flag returns before the host clears and raises the valid bit again. Randomly sized reads and writes at random addresses cover chunk counts of one to three, including exact multiples of the chunk size.

// File: rtl/bhs_pkg.sv
// Shared types and codes for the bit-header handshake slave.
// Assumes: host header uses the low nibble of byte 0; device header uses all 8 bits.
package bhs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_FETCH, ST_RD_WAIT, ST_WR_WAIT, ST_WR_PUT, ST_DONE
    } job_state_e;

    typedef struct packed {
        logic blk64;   // bit 3
        logic tgl;     // bit 2
        logic ground;  // bit 1
        logic valid;   // bit 0
    } host_hdr_t;

    localparam logic [7:0] OP_READ     = 8'h01;
    localparam logic [7:0] OP_WRITE    = 8'h02;
    localparam logic [7:0] CODE_OK     = 8'h00;
    localparam logic [7:0] CODE_BADJOB = 8'h07;
    localparam logic [7:0] CODE_HDRMIS = 8'h0F;
endpackage

// File: rtl/bhs_cmd_decode.sv
// Decodes the host output buffer: header bits, command fields and the
// acceptance verdict. Purely combinational.
// Assumes: BUF_BYTES is even and at least 4.
module bhs_cmd_decode
    import bhs_pkg::*;
#(
    parameter int BUF_BYTES = 16,
    parameter bit DUAL_HDR  = 1'b1
) (
    input  logic [BUF_BYTES*8-1:0] hbuf_i,
    output host_hdr_t              hdr_o,
    output logic [7:0]             cmd_o,
    output logic [15:0]            addr_o,
    output logic [15:0]            cnt_o,
    output logic [7:0]             verdict_o
);
    localparam int  MIN_BYTES = DUAL_HDR ? 8 : 6;
    localparam bit  SIZE_OK   = (BUF_BYTES >= MIN_BYTES);

    logic hdr_same;

    // field extraction from fixed byte positions
    always_comb begin
        hdr_o  = host_hdr_t'(hbuf_i[3:0]);
        cmd_o  = hbuf_i[15:8];
        addr_o = {hbuf_i[31:24], hbuf_i[23:16]};
        cnt_o  = {hbuf_i[47:40], hbuf_i[39:32]};
    end

    // header copy comparison only exists with the trailing header
    generate
        if (DUAL_HDR) begin : g_dual
            assign hdr_same = (hbuf_i[7:0] == hbuf_i[(BUF_BYTES-1)*8 +: 8]);
        end else begin : g_single
            assign hdr_same = 1'b1;
        end
    endgenerate

    // acceptance verdict, header mismatch ranked first
    always_comb begin
        if (!hdr_same)
            verdict_o = CODE_HDRMIS;
        else if (!SIZE_OK || cnt_o == 16'd0 || (cmd_o != OP_READ && cmd_o != OP_WRITE))
            verdict_o = CODE_BADJOB;
        else
            verdict_o = CODE_OK;
    end
endmodule

// File: rtl/bhs_job_fsm.sv
// Job sequencer: start detection, chunked read/write through the tag stub,
// toggle pacing and the start/finish/fail flags.
// Assumes: the host holds a write chunk stable until the next toggle or finish.
module bhs_job_fsm
    import bhs_pkg::*;
#(
    parameter int BUF_BYTES = 16,
    parameter bit DUAL_HDR  = 1'b1,
    localparam int CHUNK    = BUF_BYTES - 1 - int'(DUAL_HDR),
    localparam int IW       = $clog2(CHUNK + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BUF_BYTES*8-1:0] hbuf_i,
    input  host_hdr_t              hdr_i,
    input  logic [7:0]             cmd_i,
    input  logic [15:0]            addr_i,
    input  logic [15:0]            cnt_i,
    input  logic [7:0]             verdict_i,
    output logic                   started_o,
    output logic                   finished_o,
    output logic                   failed_o,
    output logic                   dtgl_o,
    output logic                   idle_o,
    output logic [7:0]             code_o,
    output logic [CHUNK*8-1:0]     rdata_o,
    output logic                   tag_req_o,
    output logic                   tag_we_o,
    output logic [15:0]            tag_addr_o,
    output logic [7:0]             tag_wdata_o,
    input  logic [7:0]             tag_rdata_i,
    input  logic                   tag_ack_i,
    output logic                   tag_blk64_o
);
    job_state_e        state;
    logic              valid_q, seen_tgl;
    logic [15:0]       addr_q, left_q;
    logic [IW-1:0]     pos_q;
    logic [7:0]        chunk_q [CHUNK];
    logic              last_byte, chunk_full;

    // tag stub drive and chunk boundary detection
    always_comb begin
        tag_req_o   = (state == ST_RD_FETCH) || (state == ST_WR_PUT);
        tag_we_o    = (state == ST_WR_PUT);
        tag_addr_o  = addr_q;
        tag_wdata_o = hbuf_i[(int'(pos_q) + 1)*8 +: 8];
        last_byte   = (left_q == 16'd1);
        chunk_full  = (pos_q == IW'(CHUNK - 1));
        idle_o      = (state == ST_IDLE);
    end

    // flatten the read chunk for the buffer packer
    generate
        for (genvar g = 0; g < CHUNK; g++) begin : g_flat
            assign rdata_o[g*8 +: 8] = chunk_q[g];
        end
    endgenerate

    // main job sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; valid_q <= 1'b0; seen_tgl <= 1'b0;
            started_o <= 1'b0; finished_o <= 1'b0; failed_o <= 1'b0;
            dtgl_o <= 1'b0; code_o <= CODE_OK; addr_q <= '0; left_q <= '0;
            pos_q <= '0; tag_blk64_o <= 1'b0;
            for (int k = 0; k < CHUNK; k++) chunk_q[k] <= 8'h00;
        end else begin
            valid_q <= hdr_i.valid;
            if (hdr_i.ground || !hdr_i.valid) begin
                state <= ST_IDLE;
                started_o <= 1'b0; finished_o <= 1'b0; failed_o <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: if (!valid_q) begin
                        seen_tgl    <= hdr_i.tgl;
                        addr_q      <= addr_i;
                        left_q      <= cnt_i;
                        pos_q       <= '0;
                        tag_blk64_o <= hdr_i.blk64;
                        if (verdict_i != CODE_OK) begin
                            failed_o <= 1'b1;
                            code_o   <= verdict_i;
                            state    <= ST_DONE;
                        end else begin
                            started_o <= 1'b1;
                            if (cmd_i == OP_READ) state <= ST_RD_FETCH;
                            else begin
                                dtgl_o <= ~dtgl_o;
                                state  <= ST_WR_WAIT;
                            end
                        end
                    end
                    ST_RD_FETCH: if (tag_ack_i) begin
                        chunk_q[pos_q] <= tag_rdata_i;
                        addr_q <= addr_q + 16'd1;
                        left_q <= left_q - 16'd1;
                        pos_q  <= pos_q + IW'(1);
                        if (last_byte) begin
                            dtgl_o <= ~dtgl_o; finished_o <= 1'b1; state <= ST_DONE;
                        end else if (chunk_full) begin
                            dtgl_o <= ~dtgl_o; state <= ST_RD_WAIT;
                        end
                    end
                    ST_RD_WAIT, ST_WR_WAIT: if (hdr_i.tgl != seen_tgl) begin
                        seen_tgl <= hdr_i.tgl;
                        pos_q    <= '0;
                        state    <= (state == ST_RD_WAIT) ? ST_RD_FETCH : ST_WR_PUT;
                    end
                    ST_WR_PUT: if (tag_ack_i) begin
                        addr_q <= addr_q + 16'd1;
                        left_q <= left_q - 16'd1;
                        pos_q  <= pos_q + IW'(1);
                        if (last_byte) begin
                            finished_o <= 1'b1; state <= ST_DONE;
                        end else if (chunk_full) begin
                            dtgl_o <= ~dtgl_o; state <= ST_WR_WAIT;
                        end
                    end
                    default: state <= state;
                endcase
            end
        end
    end
endmodule

// File: rtl/bhs_inbuf_pack.sv
// Builds the device input buffer: header byte, code or data bytes and,
// with the dual header, a copy of the header in the last byte.
// Assumes: the job flags arrive registered; the status pins are registered here.
module bhs_inbuf_pack #(
    parameter int BUF_BYTES = 16,
    parameter bit DUAL_HDR  = 1'b1,
    localparam int CHUNK    = BUF_BYTES - 1 - int'(DUAL_HDR)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tag_present_i,
    input  logic                   head_fault_i,
    input  logic                   dig_in_i,
    input  logic                   idle_i,
    input  logic                   dtgl_i,
    input  logic                   started_i,
    input  logic                   finished_i,
    input  logic                   failed_i,
    input  logic [7:0]             code_i,
    input  logic [CHUNK*8-1:0]     rdata_i,
    output logic [BUF_BYTES*8-1:0] dbuf_o
);
    logic       present_q, fault_q, din_q;
    logic [7:0] hdr_byte;

    // one-cycle registration of the status pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= 1'b0; fault_q <= 1'b0; din_q <= 1'b0;
        end else begin
            present_q <= tag_present_i; fault_q <= head_fault_i; din_q <= dig_in_i;
        end
    end

    // device header assembly in bit order 7..0
    assign hdr_byte = {idle_i, fault_q, dtgl_i, din_q, failed_i, finished_i, started_i, present_q};
    assign dbuf_o[7:0] = hdr_byte;

    // payload bytes and optional trailing header copy
    generate
        for (genvar b = 1; b < BUF_BYTES; b++) begin : g_byte
            if (DUAL_HDR && b == BUF_BYTES - 1) begin : g_copy
                assign dbuf_o[b*8 +: 8] = hdr_byte;
            end else if (b == 1) begin : g_first
                assign dbuf_o[15:8] = failed_i ? code_i : rdata_i[7:0];
            end else begin : g_data
                assign dbuf_o[b*8 +: 8] = rdata_i[(b-1)*8 +: 8];
            end
        end
    endgenerate
endmodule

// File: rtl/bithdr_slave.sv
// Top of the bit-header handshake slave: decode, job sequencer and packer.
// Assumes: BUF_BYTES even, 4..128; a buffer too small for a job rejects all jobs.
module bithdr_slave
    import bhs_pkg::*;
#(
    parameter int BUF_BYTES = 16,
    parameter bit DUAL_HDR  = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BUF_BYTES*8-1:0] hbuf_i,
    output logic [BUF_BYTES*8-1:0] dbuf_o,
    input  logic                   tag_present_i,
    input  logic                   head_fault_i,
    input  logic                   dig_in_i,
    output logic                   tag_req_o,
    output logic                   tag_we_o,
    output logic [15:0]            tag_addr_o,
    output logic [7:0]             tag_wdata_o,
    input  logic [7:0]             tag_rdata_i,
    input  logic                   tag_ack_i,
    output logic                   tag_blk64_o
);
    localparam int CHUNK = BUF_BYTES - 1 - int'(DUAL_HDR);

    host_hdr_t          hdr;
    logic [7:0]         cmd, verdict, code;
    logic [15:0]        addr, cnt;
    logic               started, finished, failed, dtgl, idle;
    logic [CHUNK*8-1:0] rdata;

    bhs_cmd_decode #(.BUF_BYTES(BUF_BYTES), .DUAL_HDR(DUAL_HDR)) u_dec (
        .hbuf_i(hbuf_i), .hdr_o(hdr), .cmd_o(cmd), .addr_o(addr),
        .cnt_o(cnt), .verdict_o(verdict)
    );

    bhs_job_fsm #(.BUF_BYTES(BUF_BYTES), .DUAL_HDR(DUAL_HDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hbuf_i(hbuf_i), .hdr_i(hdr), .cmd_i(cmd),
        .addr_i(addr), .cnt_i(cnt), .verdict_i(verdict),
        .started_o(started), .finished_o(finished), .failed_o(failed),
        .dtgl_o(dtgl), .idle_o(idle), .code_o(code), .rdata_o(rdata),
        .tag_req_o(tag_req_o), .tag_we_o(tag_we_o), .tag_addr_o(tag_addr_o),
        .tag_wdata_o(tag_wdata_o), .tag_rdata_i(tag_rdata_i),
        .tag_ack_i(tag_ack_i), .tag_blk64_o(tag_blk64_o)
    );

    bhs_inbuf_pack #(.BUF_BYTES(BUF_BYTES), .DUAL_HDR(DUAL_HDR)) u_pack (
        .clk(clk), .rst_n(rst_n), .tag_present_i(tag_present_i),
        .head_fault_i(head_fault_i), .dig_in_i(dig_in_i), .idle_i(idle),
        .dtgl_i(dtgl), .started_i(started), .finished_i(finished),
        .failed_i(failed), .code_i(code), .rdata_i(rdata), .dbuf_o(dbuf_o)
    );
endmodule

// File: rtl/bhs_checker.sv
// Port-level properties of the bit-header handshake slave, bound to the top.
module bhs_checker #(
    parameter int BUF_BYTES = 16,
    parameter bit DUAL_HDR  = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [BUF_BYTES*8-1:0] hbuf_i,
    input logic [BUF_BYTES*8-1:0] dbuf_o,
    input logic                   tag_req_o
);
    generate
        if (DUAL_HDR) begin : g_mirror
            // R10
            hdr_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dbuf_o[7:0] == dbuf_o[(BUF_BYTES-1)*8 +: 8]);
        end
    endgenerate

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hbuf_i[0] |=> (dbuf_o[3:1] == 3'b000 && dbuf_o[7]));

    // R8
    ground_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hbuf_i[1] |=> (dbuf_o[3:1] == 3'b000 && dbuf_o[7] && !tag_req_o));

    // R6
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbuf_o[3] && dbuf_o[2]));

    // R4
    tgl_in_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_o[5] != $past(dbuf_o[5])) |-> (dbuf_o[1] && !dbuf_o[3]));

    // R5
    tag_in_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_req_o |-> (dbuf_o[1] && !dbuf_o[2] && !dbuf_o[3]));

    // R1
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbuf_o[7] |-> (dbuf_o[3:1] == 3'b000));
endmodule

bind bithdr_slave bhs_checker #(.BUF_BYTES(BUF_BYTES), .DUAL_HDR(DUAL_HDR)) u_bhs_chk (
    .clk(clk), .rst_n(rst_n), .hbuf_i(hbuf_i), .dbuf_o(dbuf_o), .tag_req_o(tag_req_o)
);

// File: tb/test_bithdr_slave.sv
`timescale 1ns/1ps
module test_bithdr_slave;
    localparam int NB = 16;
    localparam bit DH = 1'b1;
    localparam int CH = NB - 1 - int'(DH);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic [NB*8-1:0] hbuf;
    logic [NB*8-1:0] dbuf;
    logic cp, hf, din;
    logic req, we, tack, blk64;
    logic [15:0] taddr;
    logic [7:0] twd, trd;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int n_chk = 0, n_fail = 0;
    logic av = 0, gr = 0, ti = 0, ct = 0;

    bithdr_slave #(.BUF_BYTES(NB), .DUAL_HDR(DH)) i_bithdr_slave (
        .clk(clk), .rst_n(rst_n), .hbuf_i(hbuf), .dbuf_o(dbuf),
        .tag_present_i(cp), .head_fault_i(hf), .dig_in_i(din),
        .tag_req_o(req), .tag_we_o(we), .tag_addr_o(taddr), .tag_wdata_o(twd),
        .tag_rdata_i(trd), .tag_ack_i(tack), .tag_blk64_o(blk64)
    );

    // zero-latency tag model
    assign tack = req;
    assign trd  = mem[taddr[7:0]];
    always @(posedge clk) if (req && we && tack) mem[taddr[7:0]] <= twd;

    function automatic logic [7:0] dby(int i);
        return dbuf[i*8 +: 8];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic put_hdr();
        logic [7:0] h;
        h = {4'b0000, ct, ti, gr, av};
        hbuf[7:0] = h;
        if (DH) hbuf[(NB-1)*8 +: 8] = h;
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cmd(logic [7:0] cmd, logic [15:0] a, logic [15:0] c);
        hbuf[15:8]  = cmd;
        hbuf[23:16] = a[7:0];
        hbuf[31:24] = a[15:8];
        hbuf[39:32] = c[7:0];
        hbuf[47:40] = c[15:8];
    endtask

    // wait for a header bit to leave a value; ok=0 on timeout
    task automatic wait_bit(int bitn, logic old, output logic ok);
        logic [7:0] h;
        ok = 1'b0;
        for (int k = 0; k < 400; k++) begin
            h = dby(0);
            if (h[bitn] !== old) begin ok = 1'b1; break; end
            tick();
        end
    endtask

    task automatic release_job(string tag);
        av = 0; put_hdr(); tick();
        check({tag, " R7 flags after valid drop"}, {24'd0, dby(0) & 8'h8E}, 32'h80);
    endtask

    task automatic do_read(logic [15:0] a, int c, string tag);
        logic [7:0] h; logic ok, old; int got;
        got = 0; h = dby(0); old = h[5];
        set_cmd(8'h01, a, 16'(c)); av = 1; put_hdr();
        while (got < c) begin
            wait_bit(5, old, ok);
            check({tag, " R4 toggle seen"}, {31'd0, ok}, 32'd1);
            if (!ok) return;
            h = dby(0); old = h[5];
            check({tag, " R1 started, not ready"}, {30'd0, h[7], h[1]}, 32'b01);
            for (int j = 0; j < CH && got + j < c; j++)
                check({tag, " R4 read data"}, {24'd0, dby(1 + j)}, {24'd0, exp_mem[(a + got + j) & 255]});
            got += (c - got < CH) ? c - got : CH;
            if (got < c) begin
                h = dby(0);
                check({tag, " R4 no finish mid read"}, {31'd0, h[2]}, 32'd0);
                ti = ~ti; put_hdr();
            end
        end
        h = dby(0);
        check({tag, " R6 finished with last toggle"}, {30'd0, h[3], h[2]}, 32'b01);
        release_job(tag);
    endtask

    task automatic do_write(logic [15:0] a, int c, string tag);
        logic [7:0] h, v; logic ok, old; int sent;
        sent = 0; h = dby(0); old = h[5];
        set_cmd(8'h02, a, 16'(c)); av = 1; put_hdr();
        while (sent < c) begin
            wait_bit(5, old, ok);
            check({tag, " R5 data request toggle"}, {31'd0, ok}, 32'd1);
            if (!ok) return;
            h = dby(0); old = h[5];
            for (int j = 0; j < CH && sent + j < c; j++) begin
                v = 8'($urandom);
                hbuf[(1 + j)*8 +: 8] = v;
                exp_mem[(a + sent + j) & 255] = v;
            end
            sent += (c - sent < CH) ? c - sent : CH;
            ti = ~ti; put_hdr();
        end
        wait_bit(2, 1'b0, ok);
        check({tag, " R6 write finished"}, {31'd0, ok}, 32'd1);
        tick();
        for (int k = (a == 0) ? 0 : int'(a) - 1; k <= int'(a) + c && k < 256; k++)
            check({tag, " R5 tag contents"}, {24'd0, mem[k]}, {24'd0, exp_mem[k]});
        release_job(tag);
    endtask

    task automatic do_err(logic [7:0] cmd, logic [15:0] c, logic bad_copy, logic [7:0] code, string tag);
        logic [7:0] h;
        set_cmd(cmd, 16'd4, c); av = 1; put_hdr();
        if (bad_copy) hbuf[(NB-1)*8 + 3] = ~hbuf[(NB-1)*8 + 3];
        tick();
        h = dby(0);
        check({tag, " failed set, started clear"}, {30'd0, h[3], h[1]}, 32'b10);
        check({tag, " code"}, {24'd0, dby(1)}, {24'd0, code});
        put_hdr();
        release_job(tag);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] h; logic ok, old;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) begin mem[i] = 8'($urandom); exp_mem[i] = mem[i]; end
        hbuf = '0; cp = 0; hf = 0; din = 0; rst_n = 0;
        tick(4); rst_n = 1; tick();
        // reset state
        check("R9 reset header", {24'd0, dby(0)}, 32'h80);
        check("R10 reset copy", {24'd0, dby(NB - 1)}, 32'h80);
        check("R8 no tag request at reset", {31'd0, req}, 32'd0);

        // status pins
        cp = 1; hf = 1; din = 1; tick(2);
        check("R9 status bits", {24'd0, dby(0)}, 32'hD1);
        check("R10 status copy", {24'd0, dby(NB - 1)}, 32'hD1);
        cp = 0; hf = 0; din = 0; tick(2);

        // directed reads and writes
        do_read(16'd3, 5, "rd5");
        do_read(16'd20, CH, "rd_exact");
        do_read(16'd40, 30, "rd30");
        do_write(16'd100, 1, "wr1");
        do_write(16'd110, 2*CH, "wr_twochunk");
        do_read(16'd108, 2*CH + 4, "rd_back");

        // block size capture
        ct = 1; do_read(16'd0, 2, "rd_ct");
        check("R11 block size held", {31'd0, blk64}, 32'd1);
        ct = 0;

        // rejections
        do_err(8'h05, 16'd4, 1'b0, 8'h07, "R2 bad command");
        do_err(8'h01, 16'd0, 1'b0, 8'h07, "R2 zero count");
        do_err(8'h02, 16'd4, 1'b1, 8'h0F, "R3 header copy mismatch");
        do_err(8'h05, 16'd0, 1'b1, 8'h0F, "R3 mismatch ranks first");

        // ground state in the middle of a read
        h = dby(0); old = h[5];
        set_cmd(8'h01, 16'd50, 16'd30); av = 1; put_hdr();
        wait_bit(5, old, ok);
        check("R8 first chunk before ground", {31'd0, ok}, 32'd1);
        gr = 1; put_hdr(); tick();
        check("R8 ground clears job", {24'd0, dby(0) & 8'h8E}, 32'h80);
        check("R8 no tag access in ground", {31'd0, req}, 32'd0);
        gr = 0; put_hdr(); tick(3);
        check("R1 held valid does not restart", {24'd0, dby(0) & 8'h8E}, 32'h80);
        release_job("R8 after ground");
        do_read(16'd50, 3, "rd_after_ground");

        // held valid after a finished job
        set_cmd(8'h01, 16'd5, 16'd1); av = 1; put_hdr(); tick(3);
        h = dby(0);
        check("R6 single byte done", {29'd0, h[3], h[2], h[1]}, 32'b011);
        tick(4);
        h = dby(0);
        check("R1 done held until valid drops", {29'd0, h[3], h[2], h[1]}, 32'b011);
        release_job("held");

        // random mix
        for (int r = 0; r < 24; r++) begin
            int c, a;
            c = 1 + int'($urandom % 40);
            a = int'($urandom % 200);
            if ($urandom % 2) do_write(16'(a), c, "rnd_wr");
            else              do_read(16'(a), c, "rnd_rd");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule